// File: doc/BRIEF.md
# Boundary-Scan Configuration Register Bank

This block is the slow-control port of a pixel sensor. A four-wire serial test port (test clock, mode select, serial data in and serial data out), together with an active-low asynchronous chip reset, walks a standard sixteen-state test access port controller. The controller steers serial data through a 5-bit instruction register and one of several data registers: a hardwired 32-bit identification word, a 1-bit bypass path, a 9-bit boundary chain over the readout control pins, an 88-bit analogue bias word holding eleven 8-bit converter codes, an 8-bit readout-mode word and a 256-bit column current-source disable mask.

Each configuration register pairs a shift stage with a parallel update stage. Capture copies the value currently applied into the shift stage. Reading a register and writing it are therefore the same access: the old setting comes out on the serial output while the new one goes in. The update stages feed the rest of the chip and change only on the falling test clock edge in Update-DR. After a chip reset every converter code is zero, which is the lowest-power bias point, all columns are enabled and the identification instruction is selected.

Top module: `scan_cfg_bank`

## Requirements
- R1: The controller moves through the sixteen standard states on the rising test clock edge. Five consecutive test clocks with mode select high reach Test-Logic-Reset from any state, and a low chip reset forces Test-Logic-Reset at once.
- R2: The instruction register is 5 bits wide and holds the identification code 5'h02 after a chip reset and whenever the controller passes through Test-Logic-Reset.
- R3: Capture-IR loads 01 into the two low instruction bits and the upper three bits of the current instruction into bits 4:2, so the first bit shifted out is 1.
- R4: Every register shifts least significant bit first. Serial output changes on the falling test clock edge, and its enable is high only in Shift-IR and Shift-DR.
- R5: Instruction 5'h02 selects a 32-bit identification register that always captures 32'hFFFF8001.
- R6: Instruction 5'h04 selects the 88-bit bias register. Converter k occupies bits 8k+7:8k (converter 10 is at 87:80, converter 0 at 7:0). A chip reset clears it to zero, and an access shifts out the applied value while the new value is shifted in.
- R7: Instruction 5'h05 selects the 256-bit column-disable mask, with bit n for column n and a 1 disabling that column's current source. It resets to zero and reads back its applied value during an access.
- R8: Instruction 5'h06 selects the 8-bit readout-mode register. It resets to zero and reads back its applied value during an access. Bit 4 chooses the first-pixel strobe behaviour, and the other bits select clock input enable, output gain and test-level mode.
- R9: The parallel outputs of the bias, mask, mode and boundary registers change only on the falling test clock edge in Update-DR. Shift and Exit1 leave them unchanged.
- R10: Codes 5'h1E and 5'h1F, and every code not listed in R5 to R11, select a 1-bit bypass register that captures 0. A bypass access leaves every configuration output unchanged.
- R11: Codes 5'h00, 5'h01 and 5'h03 select the 9-bit boundary register. Capture-DR loads the pin values and Update-DR drives the parallel boundary output. Bit 8 is the clock input, then sync in, sync out, reset marker, clock output, start marker, last row and last column, and bit 0 is the first-pixel strobe.
- R12: Reaching Test-Logic-Reset through mode select alone leaves the bias, mask and mode outputs at their applied values. Only the chip reset clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low chip reset |
| tms | input | 1 | Mode select, sampled on the rising test clock edge |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, changes on the falling test clock edge |
| tdo_en | output | 1 | High while serial data out is valid |
| bsr_pins_i | input | 9 | Pin values captured by the boundary register |
| bsr_o | output | 9 | Applied boundary register contents |
| bias_o | output | 88 | Applied converter codes, eleven 8-bit fields |
| mode_o | output | 8 | Applied readout-mode word |
| coldis_o | output | 256 | Applied column-disable mask |

## Verification
The bench builds the block with its default parameters: a 5-bit instruction, eleven 8-bit converters, a 256-column mask and a 9-bit boundary chain. With these values the full-length scans are in reach, including a 256-bit mask access whose readback must equal the previous pattern bit for bit, and bias writes whose field at bits 87:80 can be told apart from the one at bits 7:0. Because the mask is kept at full width, an off-by-one in any shift length or bit order shows up as a whole pattern moved by one position.

// File: rtl/scan_cfg_pkg.sv
package scan_cfg_pkg;

   typedef enum logic [3:0] {
      S_TLR     = 4'h0,
      S_RTI     = 4'h1,
      S_SEL_DR  = 4'h2,
      S_CAP_DR  = 4'h3,
      S_SH_DR   = 4'h4,
      S_EX1_DR  = 4'h5,
      S_PAU_DR  = 4'h6,
      S_EX2_DR  = 4'h7,
      S_UPD_DR  = 4'h8,
      S_SEL_IR  = 4'h9,
      S_CAP_IR  = 4'hA,
      S_SH_IR   = 4'hB,
      S_EX1_IR  = 4'hC,
      S_PAU_IR  = 4'hD,
      S_EX2_IR  = 4'hE,
      S_UPD_IR  = 4'hF
   } tap_state_e;

   localparam int OP_EXTEST = 'h00;
   localparam int OP_SAMPLE = 'h01;
   localparam int OP_IDENT  = 'h02;
   localparam int OP_INTEST = 'h03;
   localparam int OP_BIAS   = 'h04;
   localparam int OP_COLDIS = 'h05;
   localparam int OP_MODE   = 'h06;
   localparam int OP_BYP_A  = 'h1E;
   localparam int OP_BYP_B  = 'h1F;

   function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
      case (s)
         S_TLR:    tap_next = m ? S_TLR    : S_RTI;
         S_RTI:    tap_next = m ? S_SEL_DR : S_RTI;
         S_SEL_DR: tap_next = m ? S_SEL_IR : S_CAP_DR;
         S_CAP_DR: tap_next = m ? S_EX1_DR : S_SH_DR;
         S_SH_DR:  tap_next = m ? S_EX1_DR : S_SH_DR;
         S_EX1_DR: tap_next = m ? S_UPD_DR : S_PAU_DR;
         S_PAU_DR: tap_next = m ? S_EX2_DR : S_PAU_DR;
         S_EX2_DR: tap_next = m ? S_UPD_DR : S_SH_DR;
         S_UPD_DR: tap_next = m ? S_SEL_DR : S_RTI;
         S_SEL_IR: tap_next = m ? S_TLR    : S_CAP_IR;
         S_CAP_IR: tap_next = m ? S_EX1_IR : S_SH_IR;
         S_SH_IR:  tap_next = m ? S_EX1_IR : S_SH_IR;
         S_EX1_IR: tap_next = m ? S_UPD_IR : S_PAU_IR;
         S_PAU_IR: tap_next = m ? S_EX2_IR : S_PAU_IR;
         S_EX2_IR: tap_next = m ? S_UPD_IR : S_SH_IR;
         default:  tap_next = m ? S_SEL_DR : S_RTI;
      endcase
   endfunction

endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
   import scan_cfg_pkg::*;
(
   input  logic       tck,
   input  logic       rst_n,
   input  logic       tms,
   output tap_state_e state
);
   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) state <= S_TLR;
      else        state <= tap_next(state, tms);
   end
endmodule

// File: rtl/scan_ir.sv
module scan_ir
   import scan_cfg_pkg::*;
#(
   parameter int IR_W  = 5,
   parameter int RST_OP = OP_IDENT
) (
   input  logic            tck,
   input  logic            rst_n,
   input  tap_state_e      state,
   input  logic            tdi,
   output logic [IR_W-1:0] ir_q,
   output logic            ir_so
);
   localparam logic [IR_W-1:0] RST_CODE = IR_W'(RST_OP);

   logic [IR_W-1:0] sh;
   logic [IR_W:0]   nxt;

   assign nxt   = {tdi, sh} >> 1;
   assign ir_so = sh[0];

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)                sh <= RST_CODE;
      else if (state == S_CAP_IR) sh <= {ir_q[IR_W-1:2], 2'b01};
      else if (state == S_SH_IR)  sh <= nxt[IR_W-1:0];
   end

   always_ff @(negedge tck or negedge rst_n) begin
      if (!rst_n)                 ir_q <= RST_CODE;
      else if (state == S_TLR)    ir_q <= RST_CODE;
      else if (state == S_UPD_IR) ir_q <= sh;
   end
endmodule

// File: rtl/scan_dr_cell.sv
module scan_dr_cell #(
   parameter int           W       = 8,
   parameter logic [W-1:0] RST     = '0,
   parameter bit           HAS_UPD = 1'b1
) (
   input  logic         tck,
   input  logic         rst_n,
   input  logic         sel,
   input  logic         capture,
   input  logic         shift,
   input  logic         update,
   input  logic         tdi,
   input  logic [W-1:0] cap_val,
   output logic [W-1:0] upd_q,
   output logic         so
);
   logic [W-1:0] sh;
   logic [W:0]   nxt;

   assign nxt = {tdi, sh} >> 1;
   assign so  = sh[0];

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)               sh <= RST;
      else if (sel && capture)  sh <= cap_val;
      else if (sel && shift)    sh <= nxt[W-1:0];
   end

   generate
      if (HAS_UPD) begin : g_upd
         always_ff @(negedge tck or negedge rst_n) begin
            if (!rst_n)              upd_q <= RST;
            else if (sel && update)  upd_q <= sh;
         end
      end else begin : g_fixed
         assign upd_q = RST;
      end
   endgenerate
endmodule

// File: rtl/scan_cfg_bank.sv
module scan_cfg_bank
   import scan_cfg_pkg::*;
#(
   parameter int          IR_W   = 5,
   parameter logic [31:0] ID_VAL = 32'hFFFF8001,
   parameter int          DAC_N  = 11,
   parameter int          DAC_W  = 8,
   parameter int          MODE_W = 8,
   parameter int          COL_N  = 256,
   parameter int          BSR_W  = 9,
   localparam int         BIAS_W = DAC_N * DAC_W
) (
   input  logic              tck,
   input  logic              rst_n,
   input  logic              tms,
   input  logic              tdi,
   output logic              tdo,
   output logic              tdo_en,
   input  logic [BSR_W-1:0]  bsr_pins_i,
   output logic [BSR_W-1:0]  bsr_o,
   output logic [BIAS_W-1:0] bias_o,
   output logic [MODE_W-1:0] mode_o,
   output logic [COL_N-1:0]  coldis_o
);
   localparam int N_DR = 6;
   localparam int D_BYP = 0, D_ID = 1, D_BSR = 2, D_BIAS = 3, D_COL = 4, D_MODE = 5;

   generate
      if (IR_W != 5) begin : g_bad_ir
         $error("scan_cfg_bank: instruction codes assume a 5-bit register");
      end
      if (DAC_N < 1 || DAC_W < 1 || MODE_W < 5 || COL_N < 1 || BSR_W < 1) begin : g_bad_w
         $error("scan_cfg_bank: register widths out of range");
      end
   endgenerate

   tap_state_e      tap_state;
   logic [IR_W-1:0] ir_q;
   logic            ir_so;
   logic [N_DR-1:0] sel;
   logic [N_DR-1:0] dr_so;
   logic            dr_bit;
   logic            cap_dr, sh_dr, upd_dr;
   logic [31:0]     id_unused;
   logic            byp_unused;

   assign cap_dr = (tap_state == S_CAP_DR);
   assign sh_dr  = (tap_state == S_SH_DR);
   assign upd_dr = (tap_state == S_UPD_DR);

   scan_tap_fsm u_fsm (
      .tck(tck), .rst_n(rst_n), .tms(tms), .state(tap_state)
   );

   scan_ir #(.IR_W(IR_W), .RST_OP(OP_IDENT)) u_ir (
      .tck(tck), .rst_n(rst_n), .state(tap_state), .tdi(tdi),
      .ir_q(ir_q), .ir_so(ir_so)
   );

   always_comb begin
      sel = '0;
      case (int'(ir_q))
         OP_EXTEST, OP_SAMPLE, OP_INTEST: sel[D_BSR]  = 1'b1;
         OP_IDENT:                        sel[D_ID]   = 1'b1;
         OP_BIAS:                         sel[D_BIAS] = 1'b1;
         OP_COLDIS:                       sel[D_COL]  = 1'b1;
         OP_MODE:                         sel[D_MODE] = 1'b1;
         default:                         sel[D_BYP]  = 1'b1;
      endcase
   end

   scan_dr_cell #(.W(1), .RST(1'b0), .HAS_UPD(1'b0)) u_byp (
      .tck(tck), .rst_n(rst_n), .sel(sel[D_BYP]), .capture(cap_dr), .shift(sh_dr),
      .update(upd_dr), .tdi(tdi), .cap_val(1'b0), .upd_q(byp_unused), .so(dr_so[D_BYP])
   );

   scan_dr_cell #(.W(32), .RST(ID_VAL), .HAS_UPD(1'b0)) u_id (
      .tck(tck), .rst_n(rst_n), .sel(sel[D_ID]), .capture(cap_dr), .shift(sh_dr),
      .update(upd_dr), .tdi(tdi), .cap_val(ID_VAL), .upd_q(id_unused), .so(dr_so[D_ID])
   );

   scan_dr_cell #(.W(BSR_W), .RST('0), .HAS_UPD(1'b1)) u_bsr (
      .tck(tck), .rst_n(rst_n), .sel(sel[D_BSR]), .capture(cap_dr), .shift(sh_dr),
      .update(upd_dr), .tdi(tdi), .cap_val(bsr_pins_i), .upd_q(bsr_o), .so(dr_so[D_BSR])
   );

   scan_dr_cell #(.W(BIAS_W), .RST('0), .HAS_UPD(1'b1)) u_bias (
      .tck(tck), .rst_n(rst_n), .sel(sel[D_BIAS]), .capture(cap_dr), .shift(sh_dr),
      .update(upd_dr), .tdi(tdi), .cap_val(bias_o), .upd_q(bias_o), .so(dr_so[D_BIAS])
   );

   scan_dr_cell #(.W(COL_N), .RST('0), .HAS_UPD(1'b1)) u_col (
      .tck(tck), .rst_n(rst_n), .sel(sel[D_COL]), .capture(cap_dr), .shift(sh_dr),
      .update(upd_dr), .tdi(tdi), .cap_val(coldis_o), .upd_q(coldis_o), .so(dr_so[D_COL])
   );

   scan_dr_cell #(.W(MODE_W), .RST('0), .HAS_UPD(1'b1)) u_mode (
      .tck(tck), .rst_n(rst_n), .sel(sel[D_MODE]), .capture(cap_dr), .shift(sh_dr),
      .update(upd_dr), .tdi(tdi), .cap_val(mode_o), .upd_q(mode_o), .so(dr_so[D_MODE])
   );

   assign dr_bit = |(dr_so & sel);

   always_ff @(negedge tck or negedge rst_n) begin
      if (!rst_n) begin
         tdo    <= 1'b0;
         tdo_en <= 1'b0;
      end else if (tap_state == S_SH_IR) begin
         tdo    <= ir_so;
         tdo_en <= 1'b1;
      end else if (tap_state == S_SH_DR) begin
         tdo    <= dr_bit;
         tdo_en <= 1'b1;
      end else begin
         tdo    <= 1'b0;
         tdo_en <= 1'b0;
      end
   end
endmodule

// File: rtl/scan_cfg_bank_chk.sv
module scan_cfg_bank_chk
   import scan_cfg_pkg::*;
#(
   parameter int IR_W   = 5,
   parameter int BIAS_W = 88,
   parameter int MODE_W = 8,
   parameter int COL_N  = 256
) (
   input logic              tck,
   input logic              rst_n,
   input logic              tms,
   input tap_state_e        state,
   input logic [IR_W-1:0]   ir_q,
   input logic              ir_so,
   input logic              tdo_en,
   input logic [BIAS_W-1:0] bias,
   input logic [MODE_W-1:0] mode,
   input logic [COL_N-1:0]  coldis
);
   p_tms_reset_r1: assert property (@(posedge tck) disable iff (!rst_n)
      (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4)) |=> state == S_TLR);

   p_tlr_ident_r2: assert property (@(posedge tck) disable iff (!rst_n)
      state == S_TLR |=> ir_q == IR_W'(OP_IDENT));

   p_ir_fixed_r3: assert property (@(posedge tck) disable iff (!rst_n)
      state == S_CAP_IR |=> ir_so == 1'b1);

   p_tdo_quiet_r4: assert property (@(posedge tck) disable iff (!rst_n)
      (state != S_SH_DR && state != S_SH_IR) |-> !tdo_en);

   p_cfg_hold_r9: assert property (@(posedge tck) disable iff (!rst_n)
      state != S_UPD_DR |-> ($stable(bias) && $stable(mode) && $stable(coldis)));

   always_ff @(posedge tck) begin
      if (!rst_n) begin
         p_reset_clear_r6: assert (bias == '0 && mode == '0 && coldis == '0);
      end
   end
endmodule

bind scan_cfg_bank scan_cfg_bank_chk #(
   .IR_W(IR_W), .BIAS_W(BIAS_W), .MODE_W(MODE_W), .COL_N(COL_N)
) u_chk (
   .tck(tck), .rst_n(rst_n), .tms(tms), .state(tap_state), .ir_q(ir_q),
   .ir_so(ir_so), .tdo_en(tdo_en), .bias(bias_o), .mode(mode_o), .coldis(coldis_o)
);

// File: tb/tb_scan_cfg_bank.sv
`timescale 1ns/1ps
module tb_scan_cfg_bank;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         tms = 1'b1;
   logic         tdi = 1'b0;
   logic         tdo, tdo_en;
   logic [8:0]   pins = '0;
   logic [8:0]   bsr_o;
   logic [87:0]  bias_o;
   logic [7:0]   mode_o;
   logic [255:0] coldis_o;
   int           checks = 0;
   int           failures = 0;

   always #10 clk = ~clk;

   scan_cfg_bank dut (
      .tck(clk), .rst_n(rst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
      .bsr_pins_i(pins), .bsr_o(bsr_o), .bias_o(bias_o), .mode_o(mode_o), .coldis_o(coldis_o)
   );

   localparam int NB = 4;
   localparam logic [87:0] BIAS_TAB [NB] = '{
      88'h0102030405060708090A0B,
      88'hFFEEDDCCBBAA9988776655,
      88'h8000000000000000000001,
      88'h5A5A5A5A5A5A5A5A5A5A5A
   };

   task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic step(input logic t, input logic d, output logic o);
      @(negedge clk);
      #2;
      tms = t;
      tdi = d;
      #5;
      o = tdo;
      @(posedge clk);
      #1;
   endtask

   task automatic ir_load(input logic [4:0] code, output logic [4:0] cap);
      logic o;
      step(1, 0, o); step(1, 0, o); step(0, 0, o); step(0, 0, o);
      for (int i = 0; i < 5; i++) begin
         step(i == 4, code[i], o);
         cap[i] = o;
      end
      step(1, 0, o); step(0, 0, o);
   endtask

   task automatic dr_scan(input int n, input logic [255:0] din, output logic [255:0] dout);
      logic o;
      dout = '0;
      step(1, 0, o); step(0, 0, o); step(0, 0, o);
      for (int i = 0; i < n; i++) begin
         step(i == n - 1, din[i], o);
         dout[i] = o;
      end
   endtask

   task automatic dr_finish();
      logic o;
      step(1, 0, o); step(0, 0, o);
   endtask

   task automatic chip_reset();
      logic o;
      rst_n = 1'b0;
      tms = 1'b1;
      repeat (3) @(posedge clk);
      #3;
      rst_n = 1'b1;
      step(0, 0, o);
   endtask

   initial begin
      #(200000 * 20);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [255:0] rd;
      logic [4:0]   cap;
      logic [87:0]  prev;
      logic         o;

      #1;
      chk("R6 bias cleared during reset", 256'(bias_o), 256'(0));
      chip_reset();
      chk("R7 mask after reset", coldis_o, 256'(0));
      chk("R8 mode after reset", 256'(mode_o), 256'(0));
      chk("R4 tdo_en low in idle", 256'(tdo_en), 256'(0));

      dr_scan(32, '0, rd); dr_finish();
      chk("R5 R2 ident after reset", rd, 256'(32'hFFFF8001));

      ir_load(5'h04, cap);
      chk("R3 captured instruction", 256'(cap), 256'(5'h01));

      prev = '0;
      for (int k = 0; k < NB; k++) begin
         dr_scan(88, 256'(BIAS_TAB[k]), rd);
         chk("R9 bias held in Exit1", 256'(bias_o), 256'(prev));
         dr_finish();
         chk("R6 bias readback", rd, 256'(prev));
         chk("R6 bias applied", 256'(bias_o), 256'(BIAS_TAB[k]));
         prev = BIAS_TAB[k];
      end
      dr_scan(88, 256'(BIAS_TAB[0]), rd); dr_finish();
      chk("R6 field dac10", 256'(bias_o[87:80]), 256'(8'h01));
      chk("R6 field dac0", 256'(bias_o[7:0]), 256'(8'h0B));

      ir_load(5'h05, cap);
      chk("R3 upper bits of bias code", 256'(cap), 256'(5'h05));
      dr_scan(256, {8{32'hDEADBEEF}}, rd); dr_finish();
      chk("R7 mask readback of zero", rd, 256'(0));
      dr_scan(256, {255'(0), 1'b1}, rd); dr_finish();
      chk("R7 mask readback", rd, {8{32'hDEADBEEF}});
      chk("R7 mask applied", coldis_o, {255'(0), 1'b1});

      ir_load(5'h06, cap);
      dr_scan(8, 256'(8'h10), rd); dr_finish();
      chk("R8 mode applied bit4", 256'(mode_o), 256'(8'h10));
      dr_scan(8, 256'(8'h2D), rd); dr_finish();
      chk("R8 mode readback", rd, 256'(8'h10));

      ir_load(5'h0A, cap);
      dr_scan(8, 256'(8'hB6), rd); dr_finish();
      chk("R10 undefined code is bypass", rd, 256'({7'h36, 1'b0}));
      chk("R10 bypass leaves bias", 256'(bias_o), 256'(BIAS_TAB[0]));
      chk("R10 bypass leaves mode", 256'(mode_o), 256'(8'h2D));
      ir_load(5'h1F, cap);
      dr_scan(8, 256'(8'h81), rd); dr_finish();
      chk("R10 all-ones bypass", rd, 256'(8'h02));

      ir_load(5'h00, cap);
      pins = 9'h1A5;
      dr_scan(9, 256'(9'h0C3), rd);
      chk("R9 boundary held in Exit1", 256'(bsr_o), 256'(0));
      dr_finish();
      chk("R11 boundary capture", rd, 256'(9'h1A5));
      chk("R11 boundary update", 256'(bsr_o), 256'(9'h0C3));

      ir_load(5'h04, cap);
      for (int i = 0; i < 5; i++) step(1, 0, o);
      step(0, 0, o);
      chk("R12 bias kept after mode-select reset", 256'(bias_o), 256'(BIAS_TAB[0]));
      chk("R12 mask kept after mode-select reset", coldis_o, {255'(0), 1'b1});
      dr_scan(32, '0, rd); dr_finish();
      chk("R1 R2 five-high reset selects ident", rd, 256'(32'hFFFF8001));

      ir_load(5'h04, cap);
      step(1, 0, o); step(0, 0, o);
      rst_n = 1'b0;
      #3;
      chk("R1 async reset clears bias", 256'(bias_o), 256'(0));
      chk("R1 async reset clears mode", 256'(mode_o), 256'(0));
      chip_reset();
      dr_scan(32, '0, rd); dr_finish();
      chk("R2 ident after chip reset", rd, 256'(32'hFFFF8001));

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule